// File: doc/BRIEF.md
# Residue-Arithmetic CIC Decimator

This block is a three-stage cascaded integrator-comb decimation filter. Its integrator and comb arithmetic runs in four independent modular channels instead of wide binary accumulators. Each accepted signed two's-complement sample is first split into residues for the moduli 31, 32, 29 and 27. Each channel then runs three modular integrators at the input rate. It keeps one of every `DECIM` integrator results and passes that value through three modular combs with a differential delay of one. The four comb residues are then joined back into a signed binary value by Chinese-remainder reconstruction.

The product of the moduli, M = 776736, exceeds the full gain of the filter (DECIM^3 = 512 for the default ratio of 8) times the largest 8-bit input magnitude. The reconstructed value is therefore identical to what an ordinary binary CIC filter of the same structure produces. The stream interface is a valid strobe plus data on both sides, with no back-pressure.

Top module: `rns_cic_decimator`

## Requirements
- R1: An accepted input x (signed, IN_W bits) is held in channel k as the residue (M + x) mod m_k, for m = {31, 32, 29, 27} and M = 776736. Every representable input code maps this way.
- R2: The three integrators of every channel advance only in a cycle after a sample was accepted (inValid high at a rising edge). Data presented while inValid is low has no effect on any later output.
- R3: The combs update exactly once per DECIM accepted samples. Each comb subtracts its own input from the previous decimated instant (differential delay 1). The overall response equals ((1 - z^-DECIM)/(1 - z^-1))^3 sampled at every DECIM-th input.
- R4: All modular additions and subtractions wrap within their modulus, including subtractions with a negative intermediate. Every stored residue stays in [0, m_k).
- R5: The reconstructed value v in [0, M) is output as v when v < M/2 and as v - M otherwise. Negative filter outputs therefore appear as their signed two's-complement value.
- R6: outValid is high for exactly one cycle per DECIM accepted samples. It is asserted two rising edges after the edge that accepts the DECIM-th sample of a group.
- R7: Whenever outValid is high, outData equals the output of a binary three-stage CIC model (integrators chained within a sample, combs with delay 1, decimation by DECIM) fed with the same accepted samples.
- R8: A synchronous reset clears every integrator, comb delay, pipeline register and the decimation phase. outValid is low after reset, and the next group of DECIM samples starts from the first sample accepted after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inData | input | IN_W | Signed two's-complement input sample |
| outValid | output | 1 | One-cycle strobe for a decimated output |
| outData | output | OUT_W | Signed two's-complement filter output |

## Verification
The assertions assume that the filter's true output never leaves (-M/2, M/2). This holds only while IN_W and DECIM keep the peak gain times the largest input magnitude below M/2. The stimulus stays at the default 8-bit input and a ratio of 8, so even a constant full-scale input (about 65536 in magnitude) is far inside that range. The phase and pulse-spacing assertions also assume the decimation ratio is at least 2. The bench exercises only that setting, while sweeping every input code, both extreme constant levels, an impulse and gapped random traffic with junk data on idle cycles.

// File: rtl/rns_cic_pkg.sv
package rns_cic_pkg;

  localparam int NUM_CH  = 4;
  localparam int RES_W   = 5;
  localparam int NSTAGES = 3;

  typedef logic [RES_W-1:0] res_t;

  typedef struct packed {
    logic loadIn;
    logic integEn;
    logic combEn;
    logic crtEn;
  } stb_t;

  function automatic int unsigned modOf(input int idx);
    case (idx)
      0:       return 31;
      1:       return 32;
      2:       return 29;
      default: return 27;
    endcase
  endfunction

  function automatic longint unsigned rangeProduct();
    longint unsigned p = 1;
    for (int k = 0; k < NUM_CH; k++) p = p * modOf(k);
    return p;
  endfunction

  localparam longint unsigned DYN_RANGE = rangeProduct();

  function automatic longint unsigned modInv(input longint unsigned a, input longint unsigned m);
    for (longint unsigned k = 1; k < m; k++)
      if (((a * k) % m) == 1) return k;
    return 0;
  endfunction

  function automatic longint unsigned crtWeight(input int idx);
    longint unsigned mi  = modOf(idx);
    longint unsigned big = DYN_RANGE / mi;
    longint unsigned inv = modInv(big % mi, mi);
    return (big * inv) % DYN_RANGE;
  endfunction

  function automatic res_t modAdd(input res_t a, input res_t b, input int unsigned m);
    logic [RES_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= (RES_W+1)'(m)) s = s - (RES_W+1)'(m);
    return s[RES_W-1:0];
  endfunction

  function automatic res_t modSub(input res_t a, input res_t b, input int unsigned m);
    logic [RES_W:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + (RES_W+1)'(m) - {1'b0, b};
    return s[RES_W-1:0];
  endfunction

endpackage

// File: rtl/rns_cic_ctrl.sv
module rns_cic_ctrl
  import rns_cic_pkg::*;
#(
  parameter int DECIM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  output stb_t stb,
  output logic outValid
);

  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(DECIM - 1);

  logic aValid;
  logic bValid;
  logic [PH_W-1:0] phase;

  always_comb begin
    stb.loadIn  = inValid;
    stb.integEn = aValid;
    stb.combEn  = aValid && (phase == LAST_PH);
    stb.crtEn   = bValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aValid   <= 1'b0;
      bValid   <= 1'b0;
      outValid <= 1'b0;
      phase    <= '0;
    end else begin
      aValid   <= inValid;
      bValid   <= stb.combEn;
      outValid <= bValid;
      if (aValid) phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
    end
  end

  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PH);

  assert_comb_needs_sample_R3: assert property (@(posedge clk) disable iff (rst)
    stb.combEn |-> stb.integEn);

  assert_out_after_comb_R6: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(stb.combEn, 2));

  generate
    if (DECIM > 1) begin : g_spacing
      assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        outValid |=> !outValid);
    end
  endgenerate

endmodule

// File: rtl/rns_cic_channel.sv
module rns_cic_channel
  import rns_cic_pkg::*;
#(
  parameter int unsigned MOD = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic integEn,
  input  logic combEn,
  input  res_t resIn,
  output res_t resOut
);

  res_t integ    [NSTAGES];
  res_t integNxt [NSTAGES];
  res_t combDly  [NSTAGES];
  res_t combNxt  [NSTAGES];

  generate
    for (genvar s = 0; s < NSTAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign integNxt[s] = modAdd(integ[s], resIn, MOD);
        assign combNxt[s]  = modSub(integNxt[NSTAGES-1], combDly[s], MOD);
      end else begin : g_rest
        assign integNxt[s] = modAdd(integ[s], integNxt[s-1], MOD);
        assign combNxt[s]  = modSub(combNxt[s-1], combDly[s], MOD);
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          integ[s]   <= '0;
          combDly[s] <= '0;
        end else begin
          if (integEn) integ[s] <= integNxt[s];
          if (combEn)  combDly[s] <= (s == 0) ? integNxt[NSTAGES-1] : combNxt[s-1];
        end
      end

      assert_int_range_R4: assert property (@(posedge clk) disable iff (rst)
        integ[s] < res_t'(MOD) || MOD == (1 << RES_W));

      assert_dly_range_R4: assert property (@(posedge clk) disable iff (rst)
        combDly[s] < res_t'(MOD) || MOD == (1 << RES_W));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         resOut <= '0;
    else if (combEn) resOut <= combNxt[NSTAGES-1];
  end

  assert_int_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !integEn |=> $stable(integ[0]));

  assert_comb_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !combEn |=> $stable(resOut));

endmodule

// File: rtl/rns_cic_datapath.sv
module rns_cic_datapath
  import rns_cic_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stb_t                    stb,
  input  logic signed [IN_W-1:0]  inData,
  output logic signed [OUT_W-1:0] outData
);

  localparam longint HALF_RANGE = longint'(DYN_RANGE / 2);

  res_t        rsdA [NUM_CH];
  res_t        rsdC [NUM_CH];
  logic [63:0] term [NUM_CH];

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int unsigned  MODG = modOf(g);
      localparam longint unsigned WG = crtWeight(g);

      always_ff @(posedge clk) begin
        if (rst)             rsdA[g] <= '0;
        else if (stb.loadIn) rsdA[g] <= res_t'((longint'(DYN_RANGE) + longint'(inData)) % longint'(MODG));
      end

      rns_cic_channel #(.MOD(MODG)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .integEn (stb.integEn),
        .combEn  (stb.combEn),
        .resIn   (rsdA[g]),
        .resOut  (rsdC[g])
      );

      assign term[g] = 64'(rsdC[g]) * 64'(WG);

      assert_fwd_range_R1: assert property (@(posedge clk) disable iff (rst)
        rsdA[g] < res_t'(MODG) || MODG == (1 << RES_W));
    end
  endgenerate

  logic [63:0]        crtSum;
  logic [63:0]        crtRem;
  logic signed [63:0] crtSigned;

  always_comb begin
    crtSum = '0;
    for (int k = 0; k < NUM_CH; k++) crtSum = crtSum + term[k];
    crtRem = crtSum % 64'(DYN_RANGE);
    if (crtRem >= 64'(HALF_RANGE)) crtSigned = $signed(crtRem) - $signed(64'(DYN_RANGE));
    else                           crtSigned = $signed(crtRem);
  end

  always_ff @(posedge clk) begin
    if (rst)            outData <= '0;
    else if (stb.crtEn) outData <= OUT_W'(crtSigned);
  end

  assert_out_range_R5: assert property (@(posedge clk) disable iff (rst)
    stb.crtEn |=> (longint'(outData) >= -HALF_RANGE) && (longint'(outData) < HALF_RANGE));

endmodule

// File: rtl/rns_cic_decimator.sv
module rns_cic_decimator
  import rns_cic_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 20,
  parameter int DECIM = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);

  stb_t stb;

  rns_cic_ctrl #(.DECIM(DECIM)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  rns_cic_datapath #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: tb/sim_rns_cic_decimator.sv
module sim_rns_cic_decimator;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W  = 8;
  localparam int OUT_W = 20;
  localparam int DECIM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [IN_W-1:0] inData = '0;
  logic outValid;
  logic signed [OUT_W-1:0] outData;

  always #(CLK_PERIOD/2) clk = ~clk;

  rns_cic_decimator #(.IN_W(IN_W), .OUT_W(OUT_W), .DECIM(DECIM)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  int nChecks = 0;
  int nFails  = 0;
  string curTag = "R7";

  longint i1, i2, i3, d1, d2, d3;
  int phase;
  logic   pipeV [3];
  longint pipeD [3];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    i1 = 0; i2 = 0; i3 = 0; d1 = 0; d2 = 0; d3 = 0; phase = 0;
    for (int k = 0; k < 3; k++) begin pipeV[k] = 1'b0; pipeD[k] = 0; end
  endtask

  // one clock: check the output due now, then drive the next input
  task automatic cycle(input logic r, input logic v, input logic signed [IN_W-1:0] x);
    logic   nV;
    longint nD, c1, c2, c3;
    @(negedge clk);
    check(outValid === pipeV[2], rst ? "R8" : "R6", "outValid",
          longint'(outValid), longint'(pipeV[2]));
    if (pipeV[2] && outValid === 1'b1)
      check(longint'(outData) == pipeD[2], curTag, "outData", longint'(outData), pipeD[2]);
    pipeV[2] = pipeV[1]; pipeD[2] = pipeD[1];
    pipeV[1] = pipeV[0]; pipeD[1] = pipeD[0];
    rst = r; inValid = v; inData = x;
    nV = 1'b0; nD = 0;
    if (r) begin
      modelReset();
    end else if (v) begin
      i1 = i1 + longint'(x);
      i2 = i2 + i1;
      i3 = i3 + i2;
      phase++;
      if (phase == DECIM) begin
        phase = 0;
        c1 = i3 - d1; d1 = i3;
        c2 = c1 - d2; d2 = c1;
        c3 = c2 - d3; d3 = c2;
        nV = 1'b1; nD = c3;
      end
    end
    pipeV[0] = nV; pipeD[0] = nD;
  endtask

  task automatic lfsrStep();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    modelReset();
    // R8: reset state
    curTag = "R8";
    for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, '0);

    // R3: impulse response shape
    curTag = "R3";
    cycle(1'b0, 1'b1, 8'sd1);
    for (int k = 0; k < 6*DECIM; k++) cycle(1'b0, 1'b1, '0);

    // R4: full positive level drives every residue around its wrap
    curTag = "R4";
    for (int k = 0; k < 6*DECIM; k++) cycle(1'b0, 1'b1, 8'sd127);

    // R5: full negative level gives negative reconstructions
    curTag = "R5";
    for (int k = 0; k < 6*DECIM; k++) cycle(1'b0, 1'b1, -8'sd128);

    // R1: sweep every input code, ascending then descending
    curTag = "R1";
    for (int k = 0; k < 256; k++) cycle(1'b0, 1'b1, IN_W'(k - 128));
    for (int k = 255; k >= 0; k--) cycle(1'b0, 1'b1, IN_W'(k - 128));

    // R2: gapped traffic, junk data on idle cycles
    curTag = "R2";
    for (int k = 0; k < 400; k++) begin
      lfsrStep();
      cycle(1'b0, lfsr[0] | lfsr[5], $signed(lfsr[15:8]));
    end

    // R8: reset in mid group, then a fresh group
    curTag = "R8";
    for (int k = 0; k < 5; k++) cycle(1'b0, 1'b1, 8'sd90);
    cycle(1'b1, 1'b1, 8'sd77);
    cycle(1'b1, 1'b0, '0);
    for (int k = 0; k < 3*DECIM; k++) cycle(1'b0, 1'b1, (k == 0) ? 8'sd3 : 8'sd0);

    // R7: alternating extremes and random data
    curTag = "R7";
    for (int k = 0; k < 8*DECIM; k++) cycle(1'b0, 1'b1, k[0] ? -8'sd128 : 8'sd127);
    for (int k = 0; k < 300; k++) begin
      lfsrStep();
      cycle(1'b0, 1'b1, $signed(lfsr[7:0]));
    end

    for (int k = 0; k < 6; k++) cycle(1'b0, 1'b0, '0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule